// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches a running BCD calendar (seconds, minutes, hours, date, month and day of week) and compares it with a number of alarm register sets. The default is two. Each alarm set holds one byte per calendar field. Every byte carries an enable bit next to its BCD value, so each field takes part in the comparison only when it is enabled. Enabling only the seconds field gives an alarm once a minute. Adding minutes and hours gives a daily alarm. Adding the date gives a monthly alarm, and adding the month as well gives a yearly one.

The comparison is evaluated on a once-per-second tick. When every enabled field of a set first agrees with the live time, the block sets a sticky flag for that set. The flag stays set until a per-alarm clear strobe removes it. The interrupt request is the OR of all flags. Keeping the time, storing the registers and driving the interrupt pin are done by neighbouring blocks.

Top module: `alm_cmp_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every flag and `irq_o` is 0.
- R2: In an alarm set, byte k of the set (k=0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week) holds that field. For fields 0 to 4 the enable is bit 7 of the byte. For the day of week the enable is bit 6. A field whose enable is 0 is left out of the comparison, whatever its value.
- R3: Only the value bits of each field are compared: bits 6:0 for seconds and minutes, 5:0 for hours and date, 4:0 for month, and 2:0 for day of week. Other bits of the live time bytes (for example hour bit 7) do not change the result.
- R4: An alarm set with no enable bit set never raises its flag.
- R5: A match sets a flag only in a cycle where `tick_i` is high. A match with `tick_i` low has no effect.
- R6: A flag is set, and is visible one cycle after the tick, only on a tick where the match is true and was false on the previous tick. If the match stays true on later ticks, the flag is not set again.
- R7: A set flag stays 1 until its bit of `clr_i` is high. It then reads 0 in the next cycle.
- R8: If a clear and a new set happen for the same alarm in the same cycle, the flag stays 1.
- R9: `irq_o` is the OR of all flags, in the same cycle as the flags.
- R10: Alarm sets are independent. Clearing or matching one set does not change the flag of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Once-per-second evaluation strobe |
| now_i | input | 48 | Live time; byte k holds field k in BCD |
| alarm_i | input | 96 | Alarm sets; bits 48a+47:48a hold set a |
| clr_i | input | 2 | Per-alarm flag clear strobe |
| flag_o | output | 2 | Sticky alarm flags, bit a for set a |
| irq_o | output | 1 | Interrupt request, OR of the flags |

## Verification
A flag changes on the clock edge that samples a tick or a clear, so its new value is due one cycle after that stimulus. `irq_o` follows the flags in the same cycle. The bench drives inputs on the falling edge. One time unit after the rising edge, it steps a model built from the requirements and compares both outputs with it, so every check looks at exactly the cycle in which a result is due. Directed sequences aim at the edge-detection, clear-versus-set and no-enable cases. Random times and enables then exercise matching on a small value set, so that matches happen often.

// File: rtl/alm_pkg.sv
package alm_pkg;

    localparam int BYTE_W     = 8;
    localparam int NUM_FIELDS = 6;
    localparam int TIME_W     = NUM_FIELDS * BYTE_W;

    typedef enum int {
        FLD_SEC  = 0,
        FLD_MIN  = 1,
        FLD_HOUR = 2,
        FLD_DATE = 3,
        FLD_MON  = 4,
        FLD_DOW  = 5
    } field_e;

    typedef struct packed {
        logic any_en;
        logic hit;
    } alarm_eval_t;

    // Value bits that take part in the comparison of each field
    function automatic logic [BYTE_W-1:0] field_mask(input int idx);
        case (idx)
            FLD_SEC, FLD_MIN:   return 8'h7F;
            FLD_HOUR, FLD_DATE: return 8'h3F;
            FLD_MON:            return 8'h1F;
            default:            return 8'h07;
        endcase
    endfunction

    // Position of the enable bit inside the alarm byte
    function automatic int field_en_bit(input int idx);
        return (idx == FLD_DOW) ? 6 : 7;
    endfunction

endpackage

// File: rtl/alm_set_match.sv
module alm_set_match
    import alm_pkg::*;
(
    input  logic [TIME_W-1:0] now_i,
    input  logic [TIME_W-1:0] alarm_i,
    output alarm_eval_t       eval_o
);

    logic [NUM_FIELDS-1:0] en;
    logic [NUM_FIELDS-1:0] ok;

    generate
        for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
            localparam logic [BYTE_W-1:0] MASK   = field_mask(f);
            localparam int                EN_POS = f * BYTE_W + field_en_bit(f);
            logic [BYTE_W-1:0] diff;
            assign diff  = now_i[f*BYTE_W +: BYTE_W] ^ alarm_i[f*BYTE_W +: BYTE_W];
            assign en[f] = alarm_i[EN_POS];
            assign ok[f] = !en[f] || ((diff & MASK) == '0);
        end
    endgenerate

    always_comb begin
        eval_o.any_en = |en;
        eval_o.hit    = (|en) && (&ok);
    end

endmodule

// File: rtl/alm_flag_reg.sv
module alm_flag_reg (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic hit_i,
    input  logic clr_i,
    output logic flag_o
);

    logic prev_q;
    logic flag_q;
    logic set_now;

    assign set_now = tick_i && hit_i && !prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (tick_i) prev_q <= hit_i;
            if (set_now)     flag_q <= 1'b1;
            else if (clr_i)  flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/alm_cmp_top.sv
module alm_cmp_top
    import alm_pkg::*;
#(
    parameter int NUM_ALARMS = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         tick_i,
    input  logic [TIME_W-1:0]            now_i,
    input  logic [NUM_ALARMS*TIME_W-1:0] alarm_i,
    input  logic [NUM_ALARMS-1:0]        clr_i,
    output logic [NUM_ALARMS-1:0]        flag_o,
    output logic                         irq_o
);

    alarm_eval_t           eval [NUM_ALARMS];
    logic [NUM_ALARMS-1:0] alarm_hit;

    generate
        for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
            alm_set_match u_match (
                .now_i   (now_i),
                .alarm_i (alarm_i[a*TIME_W +: TIME_W]),
                .eval_o  (eval[a])
            );
            assign alarm_hit[a] = eval[a].hit;

            alm_flag_reg u_flag (
                .clk    (clk),
                .rst    (rst),
                .tick_i (tick_i),
                .hit_i  (alarm_hit[a]),
                .clr_i  (clr_i[a]),
                .flag_o (flag_o[a])
            );
        end
    endgenerate

    assign irq_o = |flag_o;

endmodule

// File: rtl/alm_cmp_chk.sv
module alm_cmp_chk #(
    parameter int NUM_ALARMS = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  tick_i,
    input logic [NUM_ALARMS-1:0] clr_i,
    input logic [NUM_ALARMS-1:0] flag_o,
    input logic                  irq_o,
    input logic [NUM_ALARMS-1:0] alarm_hit
);

    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (flag_o == '0 && !irq_o));

    assert_irq_follows_R9: assert property (@(posedge clk) disable iff (rst)
        (flag_o != '0) |-> irq_o);

    generate
        for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_chk
            assert_set_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
                $rose(flag_o[a]) |-> $past(tick_i));

            assert_set_needs_hit_R6: assert property (@(posedge clk) disable iff (rst)
                $rose(flag_o[a]) |-> $past(alarm_hit[a]));

            assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
                (flag_o[a] && !clr_i[a]) |=> flag_o[a]);

            assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
                (clr_i[a] && !tick_i) |=> !flag_o[a]);
        end
    endgenerate

endmodule

bind alm_cmp_top alm_cmp_chk #(.NUM_ALARMS(NUM_ALARMS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_i),
    .clr_i     (clr_i),
    .flag_o    (flag_o),
    .irq_o     (irq_o),
    .alarm_hit (alarm_hit)
);

// File: tb/alm_cmp_top_tb.sv
module alm_cmp_top_tb_top;

    localparam int NA = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_i = 1'b0;
    logic [47:0]   now_i = '0;
    logic [95:0]   alarm_i = '0;
    logic [NA-1:0] clr_i = '0;
    logic [NA-1:0] flag_o;
    logic          irq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [NA-1:0] exp_flag = '0;
    logic [NA-1:0] exp_prev = '0;

    always #5 clk = ~clk;

    alm_cmp_top #(.NUM_ALARMS(NA)) dut_i (
        .clk(clk), .rst(rst), .tick_i(tick_i), .now_i(now_i),
        .alarm_i(alarm_i), .clr_i(clr_i), .flag_o(flag_o), .irq_o(irq_o)
    );

    function automatic logic [7:0] bcd(input int n);
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    // R2/R3: expected match from field layout, enables and value widths
    function automatic logic exp_match(input logic [47:0] t, input logic [47:0] al);
        logic [7:0] msk [6] = '{8'h7F, 8'h7F, 8'h3F, 8'h3F, 8'h1F, 8'h07};
        int ebit [6] = '{7, 7, 7, 7, 7, 6};
        logic any = 1'b0;
        logic all = 1'b1;
        for (int f = 0; f < 6; f++) begin
            if (al[f*8 + ebit[f]]) begin
                any = 1'b1;
                if (((t[f*8 +: 8] ^ al[f*8 +: 8]) & msk[f]) != 8'h00) all = 1'b0;
            end
        end
        return any && all;
    endfunction

    task automatic check(input string req, input logic [NA:0] act, input logic [NA:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b (irq,flags) at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_now(input int s, input int m, input int h, input int d,
                           input int mo, input int w, input logic [7:0] hr_hi);
        now_i = {bcd(w), bcd(mo), bcd(d), bcd(h) | hr_hi, bcd(m), bcd(s)};
    endtask

    // en bits: [0]=sec .. [5]=dow
    task automatic set_alarm(input int a, input int s, input int m, input int h,
                             input int d, input int mo, input int w, input logic [5:0] en);
        alarm_i[a*48 +: 48] = {bcd(w) | {1'b0, en[5], 6'b0},
                               bcd(mo) | {en[4], 7'b0}, bcd(d) | {en[3], 7'b0},
                               bcd(h) | {en[2], 7'b0}, bcd(m) | {en[1], 7'b0},
                               bcd(s) | {en[0], 7'b0}};
    endtask

    task automatic cyc(input string req, input logic t, input logic [NA-1:0] c);
        @(negedge clk);
        tick_i = t;
        clr_i  = c;
        @(posedge clk);
        for (int a = 0; a < NA; a++) begin
            logic h;
            logic s;
            h = exp_match(now_i, alarm_i[a*48 +: 48]);
            s = t && h && !exp_prev[a];
            if (t) exp_prev[a] = h;
            if (s) exp_flag[a] = 1'b1;
            else if (c[a]) exp_flag[a] = 1'b0;
        end
        #1;
        check(req, {irq_o, flag_o}, {|exp_flag, exp_flag});
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", {irq_o, flag_o}, '0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1 after reset", {irq_o, flag_o}, '0);

        // R2: seconds-only alarm; other fields differ. R4: set 1 no enables
        set_now(30, 12, 7, 15, 6, 2, 8'h00);
        set_alarm(0, 30, 59, 23, 1, 1, 0, 6'b000001);
        set_alarm(1, 30, 12, 7, 15, 6, 2, 6'b000000);
        cyc("R2 seconds only", 1'b1, '0);
        cyc("R4 no enables", 1'b1, '0);

        // R5 match without tick, then R3 hour bit7 in live time ignored
        set_alarm(1, 0, 0, 7, 0, 0, 0, 6'b000100);
        set_now(30, 12, 7, 15, 6, 2, 8'h80);
        cyc("R5 no tick", 1'b0, '0);
        cyc("R3 hour upper bit", 1'b1, '0);

        // R10 clear only set 0; R9 irq stays from set 1
        cyc("R10 clear one", 1'b0, 2'b01);
        cyc("R9 irq from other", 1'b0, '0);
        // R6 continued match does not set again
        cyc("R6 no re-set", 1'b1, '0);
        cyc("R6 no re-set", 1'b1, '0);

        // R8 new match with clear in the same cycle
        set_now(31, 12, 7, 15, 6, 2, 8'h00);
        cyc("R6 match drops", 1'b1, '0);
        set_now(30, 12, 7, 15, 6, 2, 8'h00);
        cyc("R8 set beats clear", 1'b1, 2'b11);
        cyc("R7 sticky", 1'b0, '0);
        cyc("R7 clear both", 1'b0, 2'b11);
        cyc("R9 irq low", 1'b0, '0);

        // R2 day-of-week enable at bit 6
        set_alarm(0, 11, 22, 3, 4, 5, 3, 6'b100000);
        set_now(0, 0, 0, 1, 1, 2, 8'h00);
        cyc("R2 dow mismatch", 1'b1, '0);
        set_now(0, 0, 0, 1, 1, 3, 8'h00);
        cyc("R2 dow match", 1'b1, '0);
        // R2 yearly: month + lower fields
        set_alarm(1, 5, 4, 3, 2, 1, 0, 6'b011111);
        set_now(5, 4, 3, 2, 1, 6, 8'h00);
        cyc("R2 yearly", 1'b1, 2'b01);

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            for (int a = 0; a < NA; a++) begin
                if ($urandom % 8 == 0)
                    set_alarm(a, $urandom % 2, $urandom % 2, $urandom % 2, 1 + $urandom % 2,
                              1 + $urandom % 2, $urandom % 2, 6'($urandom));
            end
            if ($urandom % 3 == 0)
                set_now($urandom % 2, $urandom % 2, $urandom % 2, 1 + $urandom % 2,
                        1 + $urandom % 2, $urandom % 2, {$urandom % 2 == 0, 7'b0});
            cyc("R7 random", ($urandom % 3) == 0, NA'(($urandom % 5 == 0) ? $urandom : 0));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule